// File: doc/BRIEF.md
# Disk Arm Position Shadow Tracker

This block sits passively between a disk controller and a drive and keeps a cylinder number that follows the physical head arm. It listens to the controller's step request, direction and step-size lines and to the drive's ready line. It conditions the asynchronous handshake lines, captures direction and size at the right points of the handshake, and applies each completed arm step to a clamped cylinder count. A home switch re-zeroes the count whenever no step is underway.

A seek is a train of steps in one direction. Between steps the tracker stays armed, so it catches the next request as soon as the drive reports ready again. A seek ends after a quiet settle window with no new request. Any handshake wait that runs past a timeout abandons the step. The tracker then goes back to idle and raises a stall flag, which stays set until the next seek begins.

Top module: `arm_pos_tracker`

## Requirements
- R1: `step_req_i` and `drv_ready_i` pass through a synchroniser chain of SYNC_STAGES flops. Each must then hold a new level for DEB_CYC (default 2) consecutive cycles before the tracker sees it, so a one-cycle request pulse while idle starts no seek (`seek_o` stays 0).
- R2: After reset, `cyl_o` is 0, `seek_o` is 0 and `stall_o` is 0.
- R3: The direction (`dir_fwd_i` = 1 means toward higher cylinders) is taken while the first step request of a seek is high. It is kept for every later step of that seek, whatever `dir_fwd_i` does meanwhile.
- R4: The step size (`step2_i` = 1 means two cylinders, 0 means one) is sampled while the step request is high. It is held from the request's fall until that step completes, so changes on `step2_i` in that window have no effect. Each step of a seek may use a different size.
- R5: A step completes when, after the request has fallen, ready goes low and then high again. `cyl_o` changes by the captured size in the captured direction only at that return of ready.
- R6: The position never goes below 0 or above CYL_MAX (default 202). A reverse step at 0 leaves 0, and a forward step that would pass CYL_MAX leaves CYL_MAX. After a clamped step the tracker stays in the seek and accepts the next step.
- R7: After ready returns high, the tracker is armed within the seek (`seek_o` = 1) and accepts the next step request. When no request arrives within SETTLE_CYC cycles, the seek ends and `seek_o` falls.
- R8: When a request, ready-low or ready-high wait lasts TMO_CYC cycles, the tracker returns to idle (`seek_o` = 0) and sets `stall_o`. The flag stays set until the rising edge of the next step request starts a new seek.
- R9: While no step is in progress (idle, or armed between steps), an asserted `home_i` forces `cyl_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_req_i | input | 1 | Observed step request from the controller (asynchronous) |
| dir_fwd_i | input | 1 | Observed direction, 1 = toward higher cylinders |
| step2_i | input | 1 | Observed step size, 1 = two cylinders, 0 = one |
| drv_ready_i | input | 1 | Observed drive ready (asynchronous) |
| home_i | input | 1 | Home switch, high at cylinder 0 |
| cyl_o | output | $clog2(CYL_MAX+1) | Tracked cylinder number |
| seek_o | output | 1 | Seek in progress |
| stall_o | output | 1 | A handshake wait timed out |

## Verification
With default parameters, an input edge reaches the tracker's state four clock edges after it is driven: two synchroniser flops plus two debounce cycles. The position or flag update then registers one edge later. Direction, size and home go through the same chain without debounce, so they settle a cycle earlier than the request. The bench holds every handshake phase for eight cycles and samples `cyl_o` and `seek_o` ten cycles after ready returns, well past the five-edge latency and well inside the settle window. The stall flag is checked only after the timeout plus a margin of fifty cycles, and the end of a seek only after the settle window plus a margin.

// File: rtl/arm_trk_pkg.sv
package arm_trk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RDYLO,
        ST_RDYHI,
        ST_ARMED
    } trk_state_e;

endpackage

// File: rtl/arm_sig_cond.sv
module arm_sig_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 2,
    parameter bit RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC + 1) : 1;

    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic [CW-1:0]          cnt_q, cnt_d;
    logic                   out_q, out_d;
    logic                   s_last;

    assign s_last = sync_q[SYNC_STAGES-1];

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
        cnt_d  = '0;
        out_d  = out_q;
        if (s_last != out_q) begin
            if (cnt_q == CW'(DEB_CYC - 1)) begin
                out_d = s_last;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RST_VAL}};
            cnt_q  <= '0;
            out_q  <= RST_VAL;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign clean_o = out_q;

    AST_DEB_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> (out_q == $past(s_last))); // R1

endmodule

// File: rtl/arm_cyl_calc.sv
module arm_cyl_calc #(
    parameter int CYL_MAX = 202,
    parameter int CW      = $clog2(CYL_MAX + 1)
) (
    input  logic [CW-1:0] cur_i,
    input  logic          fwd_i,
    input  logic          two_i,
    output logic [CW-1:0] nxt_o
);
    logic [CW:0] delta;
    logic [CW:0] sum;

    always_comb begin
        delta = two_i ? (CW+1)'(2) : (CW+1)'(1);
        sum   = {1'b0, cur_i} + delta;
        if (fwd_i) begin
            nxt_o = (sum > (CW+1)'(CYL_MAX)) ? CW'(CYL_MAX) : sum[CW-1:0];
        end else begin
            nxt_o = ({1'b0, cur_i} < delta) ? '0 : CW'({1'b0, cur_i} - delta);
        end
    end

endmodule

// File: rtl/arm_pos_tracker.sv
module arm_pos_tracker
    import arm_trk_pkg::*;
#(
    parameter int CYL_MAX     = 202,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 2,
    parameter int TMO_CYC     = 12_500_000,
    parameter int SETTLE_CYC  = 2_500_000,
    localparam int CW         = $clog2(CYL_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_req_i,
    input  logic          dir_fwd_i,
    input  logic          step2_i,
    input  logic          drv_ready_i,
    input  logic          home_i,
    output logic [CW-1:0] cyl_o,
    output logic          seek_o,
    output logic          stall_o
);
    localparam int NCH  = 5;
    localparam int TMAX = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        trk_state_e    state;
        logic [CW-1:0] cyl;
        logic          dir_fwd;
        logic          two;
        logic          first;
        logic          req_prev;
        logic          stall;
        logic [TW-1:0] tmo;
    } trk_regs_t;

    trk_regs_t q, d;

    logic [NCH-1:0] raw_vec, cln_vec;
    logic           req_s, rdy_s, dir_s, two_s, home_s;
    logic [CW-1:0]  cyl_next;

    assign raw_vec = {home_i, step2_i, dir_fwd_i, drv_ready_i, step_req_i};

    for (genvar g = 0; g < NCH; g++) begin : g_cond
        arm_sig_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .DEB_CYC    ((g < 2) ? DEB_CYC : 1),
            .RST_VAL    (g == 1)
        ) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_vec[g]),
            .clean_o(cln_vec[g])
        );
    end

    assign req_s  = cln_vec[0];
    assign rdy_s  = cln_vec[1];
    assign dir_s  = cln_vec[2];
    assign two_s  = cln_vec[3];
    assign home_s = cln_vec[4];

    arm_cyl_calc #(
        .CYL_MAX(CYL_MAX),
        .CW     (CW)
    ) u_calc (
        .cur_i(q.cyl),
        .fwd_i(q.dir_fwd),
        .two_i(q.two),
        .nxt_o(cyl_next)
    );

    always_comb begin
        d          = q;
        d.req_prev = req_s;
        d.tmo      = q.tmo + 1'b1;
        case (q.state)
            ST_IDLE: begin
                d.tmo = '0;
                if (home_s) d.cyl = '0;
                if (req_s && !q.req_prev) begin
                    d.state = ST_REQ;
                    d.stall = 1'b0;
                    d.first = 1'b1;
                end
            end
            ST_REQ: begin
                if (q.first) d.dir_fwd = dir_s;
                d.two = two_s;
                if (!req_s) begin
                    d.state = ST_RDYLO;
                    d.tmo   = '0;
                end
            end
            ST_RDYLO: begin
                if (!rdy_s) begin
                    d.state = ST_RDYHI;
                    d.tmo   = '0;
                end
            end
            ST_RDYHI: begin
                if (rdy_s) begin
                    d.cyl   = cyl_next;
                    d.state = ST_ARMED;
                    d.first = 1'b0;
                    d.tmo   = '0;
                end
            end
            ST_ARMED: begin
                if (home_s) d.cyl = '0;
                if (req_s) begin
                    d.state = ST_REQ;
                    d.tmo   = '0;
                end else if (q.tmo == TW'(SETTLE_CYC - 1)) begin
                    d.state = ST_IDLE;
                    d.tmo   = '0;
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.tmo   = '0;
            end
        endcase
        if ((q.state == ST_REQ || q.state == ST_RDYLO || q.state == ST_RDYHI) &&
            d.state == q.state && q.tmo == TW'(TMO_CYC - 1)) begin
            d.state = ST_IDLE;
            d.stall = 1'b1;
            d.tmo   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.cyl      <= '0;
            q.dir_fwd  <= 1'b0;
            q.two      <= 1'b0;
            q.first    <= 1'b0;
            q.req_prev <= 1'b0;
            q.stall    <= 1'b0;
            q.tmo      <= '0;
        end else begin
            q <= d;
        end
    end

    assign cyl_o   = q.cyl;
    assign seek_o  = (q.state != ST_IDLE);
    assign stall_o = q.stall;

    AST_CYL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cyl <= CW'(CYL_MAX)); // R6

    AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.state == ST_REQ && q.first) |=> $stable(q.dir_fwd)); // R3

    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RDYLO || q.state == ST_RDYHI) |=> $stable(q.two)); // R4

    AST_NO_EARLY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_REQ || q.state == ST_RDYLO) |=> $stable(q.cyl)); // R5

    AST_STALL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stall) |-> (q.state == ST_IDLE)); // R8

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.tmo <= TW'(TMAX)); // R8

endmodule

// File: tb/arm_pos_tracker_tb.sv
module arm_pos_tracker_tb;
    localparam int CYL_MAX = 202;
    localparam int TMO     = 300;
    localparam int SETTLE  = 80;
    localparam int CW      = $clog2(CYL_MAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, dir = 1'b1, two = 1'b0, rdy = 1'b1, home = 1'b0;
    logic [CW-1:0] cyl;
    logic          seek, stall;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit seek_dir;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    arm_pos_tracker #(
        .CYL_MAX   (CYL_MAX),
        .TMO_CYC   (TMO),
        .SETTLE_CYC(SETTLE)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_req_i (req),
        .dir_fwd_i  (dir),
        .step2_i    (two),
        .drv_ready_i(rdy),
        .home_i     (home),
        .cyl_o      (cyl),
        .seek_o     (seek),
        .stall_o    (stall)
    );

    function automatic int next_pos(int p, bit fwd, bit sz2);
        int n;
        n = fwd ? p + (sz2 ? 2 : 1) : p - (sz2 ? 2 : 1);
        if (n < 0) n = 0;
        if (n > CYL_MAX) n = CYL_MAX;
        return n;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // one full step; first = start of a new seek
    task automatic step(bit first, bit d, bit s);
        dir = d; two = s; req = 1'b1;
        if (first) seek_dir = d;
        cyc(8);
        req = 1'b0;
        cyc(8);
        rdy = 1'b0;
        cyc(8);
        rdy = 1'b1;
        model = next_pos(model, seek_dir, s);
        cyc(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R2 cyl", int'(cyl), 0);
        chk("R2 seek", int'(seek), 0);
        chk("R2 stall", int'(stall), 0);

        // R1: single-cycle glitch must not start a seek
        req = 1'b1; cyc(1); req = 1'b0; cyc(12);
        chk("R1 glitch seek", int'(seek), 0);

        // R6: reverse at 0 clamps, seek continues
        step(1'b1, 1'b0, 1'b1);
        chk("R6 rev clamp", int'(cyl), 0);
        chk("R6 still seeking", int'(seek), 1);
        step(1'b0, 1'b1, 1'b0);
        chk("R3 dir kept reverse", int'(cyl), model);

        cyc(SETTLE + 20);
        chk("R7 seek ended", int'(seek), 0);

        // R4: size change after request fall is ignored
        seek_dir = 1'b1;
        dir = 1'b1; two = 1'b1; req = 1'b1; cyc(8);
        req = 1'b0; cyc(3); two = 1'b0; cyc(5);
        rdy = 1'b0; cyc(8); rdy = 1'b1;
        model = next_pos(model, 1'b1, 1'b1);
        cyc(10);
        chk("R4 size held", int'(cyl), model);
        chk("R7 armed between steps", int'(seek), 1);
        step(1'b0, 1'b1, 1'b0);
        chk("R4 size per step", int'(cyl), model);
        cyc(SETTLE + 20);

        // random seeks
        for (int k = 0; k < 40; k++) begin
            int nst = 1 + int'($urandom_range(3));
            for (int j = 0; j < nst; j++) begin
                step(j == 0, 1'($urandom_range(1)), 1'($urandom_range(1)));
                chk("R5 random step", int'(cyl), model);
            end
            cyc(SETTLE + 20);
            chk("R7 random seek end", int'(seek), 0);
            if ($urandom_range(7) == 0) begin
                home = 1'b1; cyc(6); home = 1'b0; cyc(4);
                model = 0;
                chk("R9 home idle", int'(cyl), 0);
            end
        end

        // R6: run to the top end
        for (int j = 0; j < 110; j++) step(j == 0, 1'b1, 1'b1);
        chk("R6 top clamp", int'(cyl), CYL_MAX);
        chk("R6 seek alive", int'(seek), 1);
        step(1'b0, 1'b1, 1'b0);
        chk("R6 top clamp size1", int'(cyl), CYL_MAX);

        // R9: home while armed
        home = 1'b1; cyc(6); home = 1'b0; cyc(4);
        model = 0;
        chk("R9 home armed", int'(cyl), 0);
        cyc(SETTLE + 20);

        // R8: request held high forever -> stall
        dir = 1'b1; two = 1'b0; req = 1'b1;
        cyc(TMO + 50);
        chk("R8 stall set", int'(stall), 1);
        chk("R8 back to idle", int'(seek), 0);
        req = 1'b0; cyc(20);
        chk("R8 stall holds", int'(stall), 1);
        chk("R8 no move", int'(cyl), model);

        // R8: new seek clears stall; then ready never returns high
        req = 1'b1; cyc(10);
        chk("R8 stall cleared", int'(stall), 0);
        req = 1'b0; cyc(8); rdy = 1'b0;
        cyc(TMO + 50);
        chk("R8 stall on ready", int'(stall), 1);
        chk("R8 pos unchanged", int'(cyl), model);
        rdy = 1'b1; cyc(20);
        chk("R5 late ready ignored", int'(cyl), model);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule